// File: doc/BRIEF.md
# PWM Fault Override Guard

This block sits between a PWM generator and the output pin of each channel. When a channel's fault input rises, the block moves that pin to a safe state at once. The safe state is either a configured logic level or high impedance. A per-channel latch then holds the override until the fault has gone and the PWM timebase reports a new period. This keeps the pin from toggling back to normal partway through a period.

Each channel has a hold-for-software option. When that option is set, the override is released only after software has cleared the channel's fault flag, and that clear must come before the period boundary that ends the override. Outside a fault, each channel can invert the PWM waveform. Each channel also has a software switch that forces the pin to high impedance at any time. Generating the PWM waveform and filtering the fault input are left to neighbouring blocks.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, every channel has no override held and a fault flag of 0. With all configuration inputs at 0 and no fault, `pin_oe` is 1 and `pin_out` equals `pwm_in`.
- R2: With no override active and `cfg_force_hiz` at 0, `pin_oe` is 1 and `pin_out` equals `pwm_in` XOR `cfg_invert`.
- R3: An override is active in any cycle where `fault_in` is 1, and in any cycle where the latch is still held. While an override is active and `cfg_safe_hiz` is 0, `pin_out` equals `cfg_safe_level`, with no clock delay after `fault_in` rises.
- R4: While an override is active and `cfg_safe_hiz` is 1, `pin_oe` is 0 and `pin_out` is 0. In that case `cfg_safe_level` has no effect.
- R5: While `cfg_force_hiz` is 1, `pin_oe` is 0 and `pin_out` is 0, whatever the fault and PWM state.
- R6: `fault_flag` becomes 1 on the first clock edge at which `fault_in` is 1. A `sw_clear` given while `fault_in` is 1 is ignored. With `fault_in` at 0, `sw_clear` sets `fault_flag` to 0.
- R7: With `cfg_hold_for_sw` at 0, a held override ends on the first clock edge at which `period_start` is 1 and `fault_in` is 0. `fault_flag` clears on that same edge.
- R8: With `cfg_hold_for_sw` at 1, a held override ends only on a clock edge at which `period_start` is 1, `fault_in` is 0, and `fault_flag` was already 0 before that edge. Period starts that occur while the flag is still set leave the override in place.
- R9: A `period_start` that arrives while `fault_in` is 1 never ends the override.
- R10: Channels are independent. A fault, clear or configuration on one channel does not change another channel's pin, enable or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | CHANNELS | Raw PWM level per channel |
| fault_in | input | CHANNELS | Active-high fault per channel |
| period_start | input | PS_W | Period-start strobe (one shared, or one per channel) |
| sw_clear | input | CHANNELS | Software fault-flag clear strobe |
| cfg_hold_for_sw | input | CHANNELS | 1: release also needs a prior software clear |
| cfg_safe_hiz | input | CHANNELS | 1: pin goes high impedance during an override |
| cfg_safe_level | input | CHANNELS | Pin level during an override |
| cfg_invert | input | CHANNELS | Invert the PWM level outside an override |
| cfg_force_hiz | input | CHANNELS | Software tri-state of the pin |
| pin_out | output | CHANNELS | Pin value (0 while not driven) |
| pin_oe | output | CHANNELS | 1 when the block drives the pin |
| fault_flag | output | CHANNELS | Fault status flag |

## Verification
The bench builds the block with CHANNELS=2 and one shared period strobe. That configuration is small enough to sweep all 32 configuration codes of channel 0 while channel 1 holds the bitwise complement. Each code runs 64 cycles of pseudo-random fault, period, clear and PWM stimulus. This puts every pairing of release mode, safe-state choice, inversion and forced tri-state in front of a per-cycle arithmetic model. It also brings same-cycle collisions within reach, such as a clear arriving together with a period start, or a period start arriving during a fault. Directed sequences then pin down the hold-for-software release order and the isolation between channels.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

   // Per-channel configuration bundle used inside the block
   typedef struct packed {
      logic hold_sw;     // release needs a prior software clear
      logic safe_hiz;    // override state is high impedance
      logic safe_level;  // override drive level
      logic invert;      // invert the normal waveform
      logic force_hiz;   // software tri-state
   } pfg_cfg_t;

   localparam int MAX_CHANNELS = 64;

endpackage

// File: rtl/pfg_fault_latch.sv
module pfg_fault_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fault_i,
   input  logic period_i,
   input  logic clear_i,
   input  logic hold_sw_i,
   output logic override_o,
   output logic flag_o
);

   logic held_q;
   logic flag_q;
   logic may_release;
   logic release_now;

   always_comb begin
      may_release = hold_sw_i ? !flag_q : 1'b1;
      release_now = held_q && !fault_i && period_i && may_release;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         held_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (fault_i)
            held_q <= 1'b1;
         else if (release_now)
            held_q <= 1'b0;

         if (fault_i)
            flag_q <= 1'b1;
         else if (clear_i || (release_now && !hold_sw_i))
            flag_q <= 1'b0;
      end
   end

   assign override_o = fault_i | held_q;
   assign flag_o     = flag_q;

   // R6: flag is set on the edge after a fault is seen
   a_r6_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i |=> flag_q);

   // R9: a fault keeps the latch held on the following cycle
   a_r9_held_after_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i |=> held_q);

   // R7: release happens only at a period start with the fault gone
   a_r7_release_at_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(held_q) |-> ($past(period_i) && !$past(fault_i)));

   // R8: in hold-for-software mode the flag was already clear before release
   a_r8_release_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(held_q) && $past(hold_sw_i)) |-> !$past(flag_q));

endmodule

// File: rtl/pfg_pin_stage.sv
module pfg_pin_stage
   import pfg_pkg::*;
(
   input  pfg_cfg_t cfg_i,
   input  logic     pwm_i,
   input  logic     override_i,
   output logic     pin_o,
   output logic     oe_o
);

   logic drive;
   logic level;

   always_comb begin
      drive = !cfg_i.force_hiz && !(override_i && cfg_i.safe_hiz);
      level = override_i ? cfg_i.safe_level : (pwm_i ^ cfg_i.invert);
      pin_o = drive & level;
      oe_o  = drive;
   end

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
   import pfg_pkg::*;
#(
   parameter int CHANNELS      = 2,
   parameter int PER_CH_PERIOD = 0,
   localparam int PS_W         = (PER_CH_PERIOD != 0) ? CHANNELS : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CHANNELS-1:0] pwm_in,
   input  logic [CHANNELS-1:0] fault_in,
   input  logic [PS_W-1:0]     period_start,
   input  logic [CHANNELS-1:0] sw_clear,
   input  logic [CHANNELS-1:0] cfg_hold_for_sw,
   input  logic [CHANNELS-1:0] cfg_safe_hiz,
   input  logic [CHANNELS-1:0] cfg_safe_level,
   input  logic [CHANNELS-1:0] cfg_invert,
   input  logic [CHANNELS-1:0] cfg_force_hiz,
   output logic [CHANNELS-1:0] pin_out,
   output logic [CHANNELS-1:0] pin_oe,
   output logic [CHANNELS-1:0] fault_flag
);

   generate
      if (CHANNELS < 1 || CHANNELS > MAX_CHANNELS) begin : g_bad_channels
         $error("pwm_fault_guard: CHANNELS out of range");
      end
      if (PER_CH_PERIOD != 0 && PER_CH_PERIOD != 1) begin : g_bad_period_mode
         $error("pwm_fault_guard: PER_CH_PERIOD must be 0 or 1");
      end
   endgenerate

   logic [CHANNELS-1:0] ps_ch;
   logic [CHANNELS-1:0] override_ch;

   for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
      pfg_cfg_t cfg;

      if (PER_CH_PERIOD != 0) begin : g_own_period
         assign ps_ch[g] = period_start[g];
      end else begin : g_shared_period
         assign ps_ch[g] = period_start[0];
      end

      assign cfg.hold_sw    = cfg_hold_for_sw[g];
      assign cfg.safe_hiz   = cfg_safe_hiz[g];
      assign cfg.safe_level = cfg_safe_level[g];
      assign cfg.invert     = cfg_invert[g];
      assign cfg.force_hiz  = cfg_force_hiz[g];

      pfg_fault_latch u_latch (
         .clk_i      (clk),
         .rst_ni     (rst_n),
         .fault_i    (fault_in[g]),
         .period_i   (ps_ch[g]),
         .clear_i    (sw_clear[g]),
         .hold_sw_i  (cfg_hold_for_sw[g]),
         .override_o (override_ch[g]),
         .flag_o     (fault_flag[g])
      );

      pfg_pin_stage u_pin (
         .cfg_i      (cfg),
         .pwm_i      (pwm_in[g]),
         .override_i (override_ch[g]),
         .pin_o      (pin_out[g]),
         .oe_o       (pin_oe[g])
      );

      // R5: software tri-state always releases the pin
      a_r5_force_hiz: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_force_hiz[g] |-> (!pin_oe[g] && !pin_out[g]));

      // R3: a driven pin shows the safe level during a fault
      a_r3_safe_level: assert property (@(posedge clk) disable iff (!rst_n)
         (fault_in[g] && pin_oe[g]) |-> (pin_out[g] == cfg_safe_level[g]));

      // R4: safe tri-state releases the pin during a fault
      a_r4_safe_hiz: assert property (@(posedge clk) disable iff (!rst_n)
         (fault_in[g] && cfg_safe_hiz[g]) |-> !pin_oe[g]);

      // R2: with no fault history and no tri-state the pin follows the waveform
      a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
         (!fault_flag[g] && !fault_in[g] && !cfg_force_hiz[g] && !cfg_hold_for_sw[g]
          && !$past(fault_in[g]) && !$past(fault_flag[g]))
         |-> (pin_oe[g] || override_ch[g]));
   end

endmodule

// File: tb/pwm_fault_guard_test.sv
module pwm_fault_guard_test;

   localparam int NCH = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] pwm_in = '0, fault_in = '0, sw_clear = '0;
   logic [0:0]     period_start = '0;
   logic [NCH-1:0] c_hold = '0, c_shz = '0, c_lvl = '0, c_inv = '0, c_fhz = '0;
   logic [NCH-1:0] pin_out, pin_oe, fault_flag;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   logic m_held [NCH];
   logic m_flag [NCH];

   always #5 clk = ~clk;

   pwm_fault_guard #(.CHANNELS(NCH), .PER_CH_PERIOD(0)) uut (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .fault_in(fault_in),
      .period_start(period_start), .sw_clear(sw_clear),
      .cfg_hold_for_sw(c_hold), .cfg_safe_hiz(c_shz), .cfg_safe_level(c_lvl),
      .cfg_invert(c_inv), .cfg_force_hiz(c_fhz),
      .pin_out(pin_out), .pin_oe(pin_oe), .fault_flag(fault_flag)
   );

   task automatic check_bit(input string tag, input int ch, input logic act, input logic exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s ch%0d t=%0t actual=%b expected=%b", tag, ch, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      for (int c = 0; c < NCH; c++) begin
         logic ov, drv, lvl;
         string tag;
         ov  = fault_in[c] | m_held[c];
         drv = !c_fhz[c] && !(ov && c_shz[c]);
         lvl = ov ? c_lvl[c] : (pwm_in[c] ^ c_inv[c]);
         if (c_fhz[c]) tag = "R5";
         else if (ov && c_shz[c]) tag = "R4";
         else if (ov && fault_in[c] && period_start[0]) tag = "R9";
         else if (ov) tag = "R3";
         else tag = "R2";
         check_bit({tag, " pin"}, c, pin_out[c], drv & lvl);
         check_bit({tag, " oe"}, c, pin_oe[c], drv);
         check_bit(m_flag[c] ? "R6 flag" : (c_hold[c] ? "R8 flag" : "R7 flag"),
                   c, fault_flag[c], m_flag[c]);
      end
   endtask

   task automatic cycle();
      #1;
      compare_all();
      @(posedge clk);
      for (int c = 0; c < NCH; c++) begin
         logic rel;
         rel = m_held[c] && !fault_in[c] && period_start[0] && (c_hold[c] ? !m_flag[c] : 1'b1);
         if (fault_in[c]) begin
            m_held[c] = 1'b1;
            m_flag[c] = 1'b1;
         end else begin
            if (rel) m_held[c] = 1'b0;
            if (sw_clear[c] || (rel && !c_hold[c])) m_flag[c] = 1'b0;
         end
      end
      #1;
   endtask

   task automatic set_cfg(input int ch, input logic [4:0] v);
      c_hold[ch] = v[4];
      c_shz[ch]  = v[3];
      c_lvl[ch]  = v[2];
      c_inv[ch]  = v[1];
      c_fhz[ch]  = v[0];
   endtask

   task automatic idle_inputs();
      fault_in = '0;
      sw_clear = '0;
      period_start = '0;
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) begin
         m_held[c] = 1'b0;
         m_flag[c] = 1'b0;
      end
      // R1: reset state
      pwm_in = 2'b01;
      repeat (3) @(posedge clk);
      #2;
      check_bit("R1 pin", 0, pin_out[0], 1'b1);
      check_bit("R1 pin", 1, pin_out[1], 1'b0);
      check_bit("R1 oe", 0, pin_oe[0], 1'b1);
      check_bit("R1 flag", 0, fault_flag[0], 1'b0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // Sweep: all configuration codes on channel 0, complement on channel 1
      begin
         logic [15:0] lfsr;
         lfsr = 16'hACE1;
         for (int code = 0; code < 32; code++) begin
            set_cfg(0, code[4:0]);
            set_cfg(1, ~code[4:0]);
            for (int k = 0; k < 64; k++) begin
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
               pwm_in          = lfsr[1:0];
               fault_in[0]     = (lfsr[4:2] == 3'd0);
               fault_in[1]     = (lfsr[9:7] == 3'd7);
               period_start[0] = (lfsr[6:5] == 2'd0);
               sw_clear        = {lfsr[11] & lfsr[12], lfsr[13] & lfsr[14]};
               cycle();
            end
            idle_inputs();
            // flush held state with a clear and a period start
            sw_clear = '1;
            cycle();
            sw_clear = '0;
            period_start = 1'b1;
            cycle();
            period_start = 1'b0;
         end
      end

      // R8: directed hold-for-software release order on channel 0
      set_cfg(0, 5'b10100);
      set_cfg(1, 5'b00000);
      pwm_in = 2'b00;
      fault_in = 2'b01;
      cycle();
      fault_in = 2'b00;
      period_start = 1'b1;
      cycle();
      period_start = 1'b0;
      #1 check_bit("R8 held without clear", 0, pin_out[0], 1'b1);
      sw_clear = 2'b01;
      period_start = 1'b1;
      cycle();
      sw_clear = 2'b00;
      #1 check_bit("R8 same-cycle clear keeps hold", 0, pin_out[0], 1'b1);
      cycle();
      period_start = 1'b0;
      #1 check_bit("R8 released", 0, pin_out[0], 1'b0);

      // R6: clear ignored while fault remains
      fault_in = 2'b01;
      sw_clear = 2'b01;
      cycle();
      cycle();
      #1 check_bit("R6 clear ignored in fault", 0, fault_flag[0], 1'b1);

      // R10: channel 1 unaffected by channel 0 fault
      pwm_in = 2'b10;
      #1;
      check_bit("R10 pin", 1, pin_out[1], 1'b1);
      check_bit("R10 flag", 1, fault_flag[1], 1'b0);
      cycle();
      idle_inputs();
      sw_clear = 2'b01;
      cycle();
      sw_clear = 2'b00;
      period_start = 1'b1;
      cycle();
      period_start = 1'b0;
      cycle();

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog t=%0t actual=running expected=finished", $time);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule